// File: doc/BRIEF.md
# Prescaled Timer Channel with Two-Point PWM

This block is one 16-bit counting channel of a timer unit. A control register chooses which clock-source tick inputs may advance the counter and how many of those ticks make one count step: the divider runs in powers of four, from 1 to 1024. Two compare registers set a wrap point (full) and a mid-period point (half). The counter climbs from zero. A step that starts at the full value returns it to zero. Each compare hit gives a one-cycle event pulse.

The same hits drive one PWM pin. On enable, the pin starts at a programmed idle level. It flips to the opposite level at the half hit and returns to the idle level at the full hit. Clearing the enable either parks the pin at the idle level at once or lets the current period finish first; a control bit chooses which. An external enable input and a stop input gate all counting. Registers are written and read through a simple select/data port.

Top module: `tmr_channel`

## Requirements
- R1: After reset, all registers and the counter are zero, and `full_evt`, `half_evt` and `pwm_out` are low.
- R2: A source tick counts only if its enable bit (control bits 2:0, bit i for `tick_in[i]`) is set, `cnt_en` is high and `stop_in` is low. Otherwise the counter holds.
- R3: The divide code in control bits 5:3 sets how many counted ticks make one counter step. Codes 0 to 5 give 1, 4, 16, 64, 256 and 1024. Codes 6 and 7 give 1.
- R4: A write to the control register clears the divider's partial count, so the next step comes a full division after the write.
- R5: A step taken while the counter equals the full register loads zero in place of counting up, and `full_evt` is high for the one cycle after that edge.
- R6: A step taken while the counter equals the half register raises `half_evt` for the one cycle after that edge.
- R7: A write to the counter (select 3) loads the written value and takes priority over a step in the same cycle.
- R8: PWM enable is control bit 7 and the idle level is control bit 8. When a write sets the enable, the pin goes to the idle level. While enabled, a half hit drives the pin to the opposite level and a full hit returns it to idle.
- R9: With control bit 9 set, a write that clears the enable shows the idle level on `pwm_out` right after that write.
- R10: With control bit 9 clear, clearing the enable leaves the pin unchanged until the next full hit, which returns it to idle. Half hits do not invert it while it is disabled.
- R11: `rd_data` returns the register picked by `rd_sel`: 0 control, 1 full, 2 half, 3 counter. Control reads return only bits 9:7 and 5:0 (mask 0x03BF).
- R12: When the full and half registers are equal, a hit pulses both events, and the full rule wins for the pin, so it returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 control, 1 full, 2 half, 3 counter |
| wr_data | input | 16 | Write data |
| rd_sel | input | 2 | Read target, same encoding as `wr_sel` |
| rd_data | output | 16 | Read data |
| cnt_en | input | 1 | External counting enable |
| stop_in | input | 1 | Stops counting while high |
| tick_in | input | 3 | One tick strobe per clock source |
| full_evt | output | 1 | Full-match pulse |
| half_evt | output | 1 | Half-match pulse |
| pwm_out | output | 1 | PWM pin |

## Verification
Directed sequences drive ticks on a disabled source, and then on an enabled source with stop set or enable clear. This separates source gating from the external gating. Divide codes 1 and 7 with short tick bursts show the power-of-four steps and the reserved-code fallback. A control rewrite in the middle of a division shows the divider restart. Separate runs with abrupt and with graceful shutdown show how the pin behaves after the enable is cleared. Equal compare values show which hit rule wins for the pin. A long seeded random run then mixes register writes, every source pattern and the gating inputs, and a bench model checks every output on every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   localparam int unsigned CODE_W    = 3;
   localparam int unsigned MAX_SRC   = 3;
   localparam int unsigned CTRL_BITS = 10;

   localparam int unsigned SRC_LSB    = 0;
   localparam int unsigned CODE_LSB   = 3;
   localparam int unsigned PWM_ON_BIT = 7;
   localparam int unsigned INIT_BIT   = 8;
   localparam int unsigned ABRUPT_BIT = 9;

   typedef enum logic [1:0] {
      SEL_CTRL  = 2'd0,
      SEL_FULL  = 2'd1,
      SEL_HALF  = 2'd2,
      SEL_COUNT = 2'd3
   } tmr_sel_e;

   typedef struct packed {
      logic               abrupt;
      logic               init_hi;
      logic               pwm_on;
      logic [CODE_W-1:0]  code;
      logic [MAX_SRC-1:0] src_en;
   } tmr_ctrl_t;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int unsigned NUM_DIV = 6,
   parameter int unsigned PRE_W   = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src_tick,
   input  logic [2:0]       code,
   input  logic             restart,
   output logic             adv,
   output logic [PRE_W-1:0] pre_cnt
);

   generate
      if (NUM_DIV == 1) begin : g_nodiv
         logic unused_ok;
         assign unused_ok = ^{clk, rst_n, code, restart};
         assign adv       = src_tick;
         assign pre_cnt   = '0;
      end else begin : g_div
         if (PRE_W < 2 * (NUM_DIV - 1)) begin : g_bad_w
            $error("tmr_prescaler: PRE_W too narrow for NUM_DIV");
         end

         function automatic logic [PRE_W-1:0] terminal_of(input logic [2:0] c);
            logic [PRE_W-1:0] t;
            t = '0;
            for (int k = 1; k < NUM_DIV; k++) begin
               if (c == 3'(k)) t = PRE_W'((64'd1 << (2 * k)) - 64'd1);
            end
            return t;
         endfunction

         logic [PRE_W-1:0] cnt_q;
         logic [PRE_W-1:0] term;
         logic             hit;

         assign term    = terminal_of(code);
         assign hit     = src_tick && (cnt_q == term);
         assign adv     = hit;
         assign pre_cnt = cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (restart || hit) begin
               cnt_q <= '0;
            end else if (src_tick) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] full_val,
   input  logic [CNT_W-1:0] half_val,
   output logic [CNT_W-1:0] cnt,
   output logic             full_hit,
   output logic             half_hit,
   output logic             full_evt,
   output logic             half_evt
);

   logic [CNT_W-1:0] cnt_q;

   assign cnt      = cnt_q;
   assign full_hit = adv && (cnt_q == full_val);
   assign half_hit = adv && (cnt_q == half_val);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         full_evt <= 1'b0;
         half_evt <= 1'b0;
      end else begin
         full_evt <= full_hit;
         half_evt <= half_hit;
         if (load) begin
            cnt_q <= load_val;
         end else if (full_hit) begin
            cnt_q <= '0;
         end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/tmr_pwm.sv
module tmr_pwm (
   input  logic clk,
   input  logic rst_n,
   input  logic pwm_on,
   input  logic init_hi,
   input  logic abrupt,
   input  logic start,
   input  logic start_lvl,
   input  logic full_hit,
   input  logic half_hit,
   output logic pwm_out
);

   logic lvl_q;
   logic park;

   assign park    = !pwm_on && abrupt;
   assign pwm_out = park ? init_hi : lvl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= 1'b0;
      end else if (start) begin
         lvl_q <= start_lvl;
      end else if (park) begin
         lvl_q <= init_hi;
      end else if (full_hit) begin
         lvl_q <= init_hi;
      end else if (half_hit && pwm_on) begin
         lvl_q <= !init_hi;
      end
   end

endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int unsigned CNT_W   = 16,
   parameter int unsigned NUM_SRC = 3,
   parameter int unsigned NUM_DIV = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [CNT_W-1:0]   wr_data,
   input  logic [1:0]         rd_sel,
   output logic [CNT_W-1:0]   rd_data,
   input  logic               cnt_en,
   input  logic               stop_in,
   input  logic [NUM_SRC-1:0] tick_in,
   output logic               full_evt,
   output logic               half_evt,
   output logic               pwm_out
);

   localparam int unsigned PRE_W = (NUM_DIV > 1) ? 2 * (NUM_DIV - 1) : 1;

   generate
      if (CNT_W < CTRL_BITS || CNT_W > 32) begin : g_bad_cnt_w
         $error("tmr_channel: CNT_W must lie in 10..32");
      end
      if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
         $error("tmr_channel: NUM_SRC must lie in 1..3");
      end
      if (NUM_DIV < 1 || NUM_DIV > (1 << CODE_W)) begin : g_bad_div
         $error("tmr_channel: NUM_DIV must lie in 1..8");
      end
   endgenerate

   tmr_ctrl_t        ctrl_q;
   tmr_ctrl_t        ctrl_new;
   logic [CNT_W-1:0] full_q;
   logic [CNT_W-1:0] half_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] ctrl_rd;
   logic [PRE_W-1:0] pre_q;

   logic ctrl_wr;
   logic cnt_load;
   logic src_tick;
   logic adv;
   logic full_hit;
   logic half_hit;
   logic pwm_start;
   logic [NUM_SRC-1:0] gated;

   assign ctrl_wr  = wr_en && (tmr_sel_e'(wr_sel) == SEL_CTRL);
   assign cnt_load = wr_en && (tmr_sel_e'(wr_sel) == SEL_COUNT);

   always_comb begin
      ctrl_new         = '0;
      ctrl_new.code    = wr_data[CODE_LSB +: CODE_W];
      ctrl_new.pwm_on  = wr_data[PWM_ON_BIT];
      ctrl_new.init_hi = wr_data[INIT_BIT];
      ctrl_new.abrupt  = wr_data[ABRUPT_BIT];
      for (int i = 0; i < NUM_SRC; i++) begin
         ctrl_new.src_en[i] = wr_data[SRC_LSB + i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         full_q <= '0;
         half_q <= '0;
      end else if (wr_en) begin
         case (tmr_sel_e'(wr_sel))
            SEL_CTRL: ctrl_q <= ctrl_new;
            SEL_FULL: full_q <= wr_data;
            SEL_HALF: half_q <= wr_data;
            default:  ;
         endcase
      end
   end

   genvar g;
   generate
      for (g = 0; g < NUM_SRC; g++) begin : g_src
         assign gated[g] = tick_in[g] & ctrl_q.src_en[g];
      end
   endgenerate

   assign src_tick = cnt_en && !stop_in && (|gated);

   tmr_prescaler #(
      .NUM_DIV (NUM_DIV),
      .PRE_W   (PRE_W)
   ) pre_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .src_tick (src_tick),
      .code     (ctrl_q.code),
      .restart  (ctrl_wr),
      .adv      (adv),
      .pre_cnt  (pre_q)
   );

   tmr_counter #(
      .CNT_W (CNT_W)
   ) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .adv      (adv),
      .load     (cnt_load),
      .load_val (wr_data),
      .full_val (full_q),
      .half_val (half_q),
      .cnt      (cnt_q),
      .full_hit (full_hit),
      .half_hit (half_hit),
      .full_evt (full_evt),
      .half_evt (half_evt)
   );

   assign pwm_start = ctrl_wr && ctrl_new.pwm_on && !ctrl_q.pwm_on;

   tmr_pwm pwm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwm_on    (ctrl_q.pwm_on),
      .init_hi   (ctrl_q.init_hi),
      .abrupt    (ctrl_q.abrupt),
      .start     (pwm_start),
      .start_lvl (ctrl_new.init_hi),
      .full_hit  (full_hit),
      .half_hit  (half_hit),
      .pwm_out   (pwm_out)
   );

   always_comb begin
      ctrl_rd                          = '0;
      ctrl_rd[SRC_LSB +: MAX_SRC]      = ctrl_q.src_en;
      ctrl_rd[CODE_LSB +: CODE_W]      = ctrl_q.code;
      ctrl_rd[PWM_ON_BIT]              = ctrl_q.pwm_on;
      ctrl_rd[INIT_BIT]                = ctrl_q.init_hi;
      ctrl_rd[ABRUPT_BIT]              = ctrl_q.abrupt;
   end

   always_comb begin
      case (tmr_sel_e'(rd_sel))
         SEL_CTRL: rd_data = ctrl_rd;
         SEL_FULL: rd_data = full_q;
         SEL_HALF: rd_data = half_q;
         default:  rd_data = cnt_q;
      endcase
   end

endmodule

// File: rtl/tmr_channel_chk.sv
module tmr_channel_chk #(
   parameter int unsigned CNT_W = 16,
   parameter int unsigned PRE_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ctrl_wr,
   input logic             cnt_load,
   input logic             stop_in,
   input logic             pwm_on,
   input logic [CNT_W-1:0] cnt_q,
   input logic [CNT_W-1:0] full_q,
   input logic [CNT_W-1:0] half_q,
   input logic [PRE_W-1:0] pre_q,
   input logic             full_evt,
   input logic             half_evt,
   input logic             pwm_out
);

   // R2
   stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_in && !cnt_load) |=> $stable(cnt_q));

   // R4
   pre_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (pre_q == '0));

   // R5
   full_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full_evt |-> ($past(cnt_q) == $past(full_q)));

   // R6
   half_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      half_evt |-> ($past(cnt_q) == $past(half_q)));

   // R8
   pwm_edge_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_on && $past(pwm_on) && !$past(ctrl_wr) && !$stable(pwm_out))
         |-> (full_evt || half_evt));

endmodule

bind tmr_channel tmr_channel_chk #(
   .CNT_W (CNT_W),
   .PRE_W (PRE_W)
) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctrl_wr  (ctrl_wr),
   .cnt_load (cnt_load),
   .stop_in  (stop_in),
   .pwm_on   (ctrl_q.pwm_on),
   .cnt_q    (cnt_q),
   .full_q   (full_q),
   .half_q   (half_q),
   .pre_q    (pre_q),
   .full_evt (full_evt),
   .half_evt (half_evt),
   .pwm_out  (pwm_out)
);

// File: tb/tmr_channel_tb_top.sv
`timescale 1ns/1ps
module tmr_channel_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [15:0] wr_data = 16'd0;
   logic [1:0]  rd_sel = 2'd3;
   logic [15:0] rd_data;
   logic        cnt_en = 1'b0;
   logic        stop_in = 1'b0;
   logic [2:0]  tick_in = 3'd0;
   logic        full_evt;
   logic        half_evt;
   logic        pwm_out;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;
   logic [1:0] rsel = 2'd3;

   // model state
   logic [9:0]  m_ctrl;
   logic [15:0] m_full, m_half, m_cnt;
   int          m_pre;
   logic        m_lvl, m_fe, m_he;

   always #4 clk = ~clk;

   tmr_channel dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .rd_sel   (rd_sel),
      .rd_data  (rd_data),
      .cnt_en   (cnt_en),
      .stop_in  (stop_in),
      .tick_in  (tick_in),
      .full_evt (full_evt),
      .half_evt (half_evt),
      .pwm_out  (pwm_out)
   );

   function automatic int div_of(input logic [2:0] c);
      return (c < 3'd6) ? (1 << (2 * c)) : 1;
   endfunction

   function automatic logic [15:0] exp_rd(input logic [1:0] s);
      case (s)
         2'd0:    return {6'd0, m_ctrl};
         2'd1:    return m_full;
         2'd2:    return m_half;
         default: return m_cnt;
      endcase
   endfunction

   function automatic logic exp_pwm();
      return (!m_ctrl[7] && m_ctrl[9]) ? m_ctrl[8] : m_lvl;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      m_ctrl = '0; m_full = '0; m_half = '0; m_cnt = '0;
      m_pre = 0; m_lvl = 1'b0; m_fe = 1'b0; m_he = 1'b0;
   endtask

   task automatic model_step(input logic we, input logic [1:0] sel,
                             input logic [15:0] d, input logic en,
                             input logic stp, input logic [2:0] tk);
      logic src, adv, fh, hh, cw;
      src = en && !stp && ((tk & m_ctrl[2:0]) != 3'd0);
      adv = src && (m_pre == div_of(m_ctrl[5:3]) - 1);
      fh  = adv && (m_cnt == m_full);
      hh  = adv && (m_cnt == m_half);
      cw  = we && (sel == 2'd0);
      if (cw && d[7] && !m_ctrl[7])      m_lvl = d[8];
      else if (!m_ctrl[7] && m_ctrl[9])  m_lvl = m_ctrl[8];
      else if (fh)                       m_lvl = m_ctrl[8];
      else if (hh && m_ctrl[7])          m_lvl = !m_ctrl[8];
      if (cw || adv)  m_pre = 0;
      else if (src)   m_pre = m_pre + 1;
      if (we && sel == 2'd3) m_cnt = d;
      else if (fh)           m_cnt = '0;
      else if (adv)          m_cnt = m_cnt + 16'd1;
      if (we && sel == 2'd1) m_full = d;
      if (we && sel == 2'd2) m_half = d;
      if (cw) m_ctrl = d[9:0] & 10'h3BF;
      m_fe = fh;
      m_he = hh;
   endtask

   task automatic compare_all();
      chk("R11", "rd_data", rd_data, exp_rd(rd_sel));
      chk("R5", "full_evt", {15'd0, full_evt}, {15'd0, m_fe});
      chk("R6", "half_evt", {15'd0, half_evt}, {15'd0, m_he});
      chk("R8", "pwm_out", {15'd0, pwm_out}, {15'd0, exp_pwm()});
   endtask

   task automatic cyc(input logic we, input logic [1:0] sel, input logic [15:0] d,
                      input logic en, input logic stp, input logic [2:0] tk);
      @(negedge clk);
      compare_all();
      wr_en = we; wr_sel = sel; wr_data = d;
      cnt_en = en; stop_in = stp; tick_in = tk; rd_sel = rsel;
      model_step(we, sel, d, en, stp, tk);
   endtask

   task automatic wr(input logic [1:0] sel, input logic [15:0] d);
      cyc(1'b1, sel, d, 1'b0, 1'b0, 3'd0);
   endtask

   task automatic ticks(input int n, input logic [2:0] tk);
      repeat (n) cyc(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, tk);
   endtask

   task automatic peek();
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
         $finish;
      end
   end

   initial begin
      logic [2:0] codes [5];
      codes = '{3'd0, 3'd1, 3'd6, 3'd7, 3'd2};
      void'($urandom(32'd20240611));
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      peek();
      // R1 reset state
      chk("R1", "count", rd_data, 16'd0);
      chk("R1", "pwm_out", {15'd0, pwm_out}, 16'd0);
      chk("R1", "events", {14'd0, full_evt, half_evt}, 16'd0);

      // R3 divide by 4
      wr(2'd1, 16'd1000); wr(2'd0, 16'h0009); wr(2'd3, 16'd0);
      ticks(8, 3'b001); peek();
      chk("R3", "count after 8 ticks div4", rd_data, 16'd2);
      // R3 reserved code acts as divide by 1
      wr(2'd0, 16'h0039); wr(2'd3, 16'd0);
      ticks(5, 3'b001); peek();
      chk("R3", "count after 5 ticks code7", rd_data, 16'd5);
      // R4 control write restarts the divider
      wr(2'd0, 16'h0009); wr(2'd3, 16'd0);
      ticks(3, 3'b001);
      wr(2'd0, 16'h0009);
      ticks(3, 3'b001); peek();
      chk("R4", "count 3 ticks after rewrite", rd_data, 16'd0);
      ticks(1, 3'b001); peek();
      chk("R4", "count 4 ticks after rewrite", rd_data, 16'd1);
      // R2 source and external gating
      wr(2'd0, 16'h0002); wr(2'd3, 16'd0);
      ticks(4, 3'b001); peek();
      chk("R2", "disabled source", rd_data, 16'd0);
      repeat (3) cyc(1'b0, 2'd0, 16'd0, 1'b1, 1'b1, 3'b010);
      peek();
      chk("R2", "stop high", rd_data, 16'd0);
      repeat (2) cyc(1'b0, 2'd0, 16'd0, 1'b0, 1'b0, 3'b010);
      peek();
      chk("R2", "enable low", rd_data, 16'd0);
      ticks(2, 3'b010); peek();
      chk("R2", "enabled source", rd_data, 16'd2);
      // R5 / R6 matches
      wr(2'd1, 16'd3); wr(2'd2, 16'd1); wr(2'd0, 16'h0001); wr(2'd3, 16'd0);
      ticks(2, 3'b001); peek();
      chk("R6", "half_evt", {15'd0, half_evt}, 16'd1);
      chk("R6", "count at half", rd_data, 16'd2);
      ticks(2, 3'b001); peek();
      chk("R5", "full_evt", {15'd0, full_evt}, 16'd1);
      chk("R5", "count wrapped", rd_data, 16'd0);
      // R8 PWM waveform
      wr(2'd0, 16'h0181); peek();
      chk("R8", "pwm at enable", {15'd0, pwm_out}, 16'd1);
      ticks(2, 3'b001); peek();
      chk("R8", "pwm after half", {15'd0, pwm_out}, 16'd0);
      ticks(2, 3'b001); peek();
      chk("R8", "pwm after full", {15'd0, pwm_out}, 16'd1);
      // R9 abrupt shutdown
      wr(2'd0, 16'h0381);
      ticks(2, 3'b001); peek();
      chk("R8", "pwm inverted", {15'd0, pwm_out}, 16'd0);
      wr(2'd0, 16'h0301); peek();
      chk("R9", "pwm parked", {15'd0, pwm_out}, 16'd1);
      ticks(2, 3'b001); peek();
      chk("R9", "pwm stays parked", {15'd0, pwm_out}, 16'd1);
      // R10 graceful shutdown
      wr(2'd0, 16'h0181);
      ticks(2, 3'b001);
      wr(2'd0, 16'h0101); peek();
      chk("R10", "pwm held after disable", {15'd0, pwm_out}, 16'd0);
      ticks(1, 3'b001); peek();
      chk("R10", "pwm held before full", {15'd0, pwm_out}, 16'd0);
      ticks(1, 3'b001); peek();
      chk("R10", "pwm idle at full", {15'd0, pwm_out}, 16'd1);
      ticks(2, 3'b001); peek();
      chk("R10", "no half inversion", {15'd0, pwm_out}, 16'd1);
      // R7 load beats step
      wr(2'd1, 16'd20);
      cyc(1'b1, 2'd3, 16'd7, 1'b1, 1'b0, 3'b001); peek();
      chk("R7", "loaded count", rd_data, 16'd7);
      // R12 equal compares
      wr(2'd1, 16'd2); wr(2'd2, 16'd2); wr(2'd3, 16'd0); wr(2'd0, 16'h0181);
      ticks(3, 3'b001); peek();
      chk("R12", "full_evt", {15'd0, full_evt}, 16'd1);
      chk("R12", "half_evt", {15'd0, half_evt}, 16'd1);
      chk("R12", "pwm idle", {15'd0, pwm_out}, 16'd1);
      // R11 readback
      rsel = 2'd0;
      wr(2'd0, 16'hFFFF); peek();
      chk("R11", "ctrl mask", rd_data, 16'h03BF);
      rsel = 2'd1;
      cyc(1'b0, 2'd0, 16'd0, 1'b0, 1'b0, 3'd0); peek();
      chk("R11", "full read", rd_data, 16'd2);
      rsel = 2'd3;

      // random phase, every output compared each cycle
      wr(2'd0, 16'h0081);
      for (int i = 0; i < 20000; i++) begin
         logic        we;
         logic [1:0]  sel;
         logic [15:0] d;
         we  = ($urandom % 20) == 0;
         sel = 2'($urandom % 4);
         if (sel == 2'd0) begin
            d = 16'($urandom) & 16'h0387;
            d[5:3] = codes[$urandom % 5];
         end else begin
            d = 16'($urandom % 16);
         end
         rsel = 2'($urandom % 4);
         cyc(we, sel, d, ($urandom % 10) != 0, ($urandom % 10) == 0, 3'($urandom));
      end
      @(negedge clk);
      compare_all();

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
   end

endmodule